// File: doc/BRIEF.md
# Paired-Input Sequence Detector

The block watches a two-bit input pair that is sampled on every rising clock edge. It raises a single-bit match flag when the pairs 00, 00, 11 and 10 arrive in that order on consecutive cycles. The flag is a Mealy output. It is decoded from the registered state together with the pair present on the inputs now. This means the flag rises in the same cycle as the final 10 pair, before that pair is clocked in.

The state is held in two flip-flops that encode four states. An idle state means no useful prefix has been seen. Three further states record a prefix of one 00, two or more 00 pairs, or 00-00-11. A long run of 00 pairs keeps the machine in the two-zeros state, so a run of any length can start a match. The flag stays combinational, so a consumer that needs a clean level must sample it at a clock edge.

Top module: `pair_seq_detector`

## Requirements
- R1: While `rst_n` is low the state is forced to idle (encoding 00) without waiting for a clock edge, and `match` is 0 whatever the inputs are. A new match needs a full four-pair sequence after release.
- R2: `match` is 1 exactly when the current pair {in_a,in_b} is 10 and the three pairs sampled on the last three edges since reset were, oldest first, 00, 00, 11. In every other case `match` is 0.
- R3: From idle, pair 00 moves to the one-zero state (encoding 01). Pairs 01, 10 and 11 leave the machine in idle.
- R4: From the one-zero state, pair 00 moves to the two-zeros state (encoding 11). Any other pair returns to idle.
- R5: From the two-zeros state, pair 00 stays there and pair 11 moves to the armed state (encoding 10). Pairs 01 and 10 return to idle. Runs of 00 of any length therefore still lead to a match.
- R6: From the armed state, pair 00 moves to the one-zero state. Pairs 01, 11 and the matching pair 10 all return to idle, so two matches are at least four cycles apart.
- R7: `match` follows the inputs with no clock delay. In the armed state it rises and falls within a cycle as the pair toggles between 10 and another value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| in_a | input | 1 | High bit of the input pair |
| in_b | input | 1 | Low bit of the input pair |
| match | output | 1 | Combinational flag for the completed 00, 00, 11, 10 sequence |

## Verification
The hardest cases to reach from the ports are the two re-entry paths. One is the two-zeros state looping on itself through a long run of 00 pairs. The other is the armed state falling back to one-zero on a 00, where a new match must still be found two pairs later. Directed scenarios build 00 runs of several lengths, break an armed prefix with a 00, and toggle the pair within a single armed cycle to expose the combinational flag. A random stream biased heavily toward 00 then reaches these paths many more times than uniform stimulus would.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

  localparam int PAIR_W  = 2;
  localparam int STATE_W = 2;

  // adjacent-code assignment: successive prefix states differ in one bit
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ZERO1 = 2'b01,
    ST_ZERO2 = 2'b11,
    ST_ARMED = 2'b10
  } det_state_e;

  localparam logic [PAIR_W-1:0] PAIR_LL = 2'b00;
  localparam logic [PAIR_W-1:0] PAIR_HH = 2'b11;
  localparam logic [PAIR_W-1:0] PAIR_HL = 2'b10;

endpackage

// File: rtl/pair_seq_next.sv
module pair_seq_next
  import pair_seq_pkg::*;
(
  input  det_state_e              cur_state,
  input  logic [PAIR_W-1:0]       pair,
  output det_state_e              nxt_state
);

  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE: begin
        if (pair == PAIR_LL) nxt_state = ST_ZERO1;
      end
      ST_ZERO1: begin
        if (pair == PAIR_LL) nxt_state = ST_ZERO2;
      end
      ST_ZERO2: begin
        if (pair == PAIR_LL)      nxt_state = ST_ZERO2;
        else if (pair == PAIR_HH) nxt_state = ST_ARMED;
      end
      ST_ARMED: begin
        if (pair == PAIR_LL) nxt_state = ST_ZERO1;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pair_seq_reg.sv
module pair_seq_reg
  import pair_seq_pkg::*;
#(
  parameter det_state_e RESET_STATE = ST_IDLE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  det_state_e d_state,
  output det_state_e q_state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_state <= RESET_STATE;
    else        q_state <= d_state;
  end

endmodule

// File: rtl/pair_seq_out.sv
module pair_seq_out
  import pair_seq_pkg::*;
(
  input  det_state_e        cur_state,
  input  logic [PAIR_W-1:0] pair,
  output logic              hit
);

  always_comb begin
    hit = (cur_state == ST_ARMED) && (pair == PAIR_HL);
  end

endmodule

// File: rtl/pair_seq_detector.sv
module pair_seq_detector
  import pair_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  output logic match
);

  logic [PAIR_W-1:0] pair;
  det_state_e        state_q;
  det_state_e        state_d;

  assign pair = {in_a, in_b};

  pair_seq_next next_i (
    .cur_state (state_q),
    .pair      (pair),
    .nxt_state (state_d)
  );

  pair_seq_reg #(
    .RESET_STATE (ST_IDLE)
  ) reg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_state (state_d),
    .q_state (state_q)
  );

  pair_seq_out out_i (
    .cur_state (state_q),
    .pair      (pair),
    .hit       (match)
  );

endmodule

// File: rtl/pair_seq_chk.sv
module pair_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_a,
  input logic       in_b,
  input logic       match,
  input logic [1:0] state
);

  logic [1:0] pair;
  logic [1:0] h0, h1, h2;
  logic [1:0] seen;
  logic       window_ok;

  assign pair = {in_a, in_b};

  // independent record of the last three sampled pairs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0   <= 2'b00;
      h1   <= 2'b00;
      h2   <= 2'b00;
      seen <= 2'd0;
    end else begin
      h0 <= pair;
      h1 <= h0;
      h2 <= h1;
      if (seen != 2'd3) seen <= seen + 2'd1;
    end
  end

  assign window_ok = (seen == 2'd3) && (h2 == 2'b00) && (h1 == 2'b00) && (h0 == 2'b11);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!match && state == 2'b00));

  assert_hit_found_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (window_ok && pair == 2'b10) |-> match);

  assert_hit_genuine_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (window_ok && pair == 2'b10));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00 && pair != 2'b00) |=> state == 2'b00);

  assert_zero_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b11 && pair == 2'b00) |=> state == 2'b11);

  assert_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> state == 2'b00);

endmodule

bind pair_seq_detector pair_seq_chk chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .in_a  (in_a),
  .in_b  (in_b),
  .match (match),
  .state (state_q)
);

// File: tb/pair_seq_detector_tb_top.sv
module pair_seq_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk;
  logic rst_n;
  logic in_a;
  logic in_b;
  logic match;

  int checks;
  int errors;
  logic [1:0] m0, m1, m2;
  int m_seen;
  bit done;

  pair_seq_detector dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .in_a  (in_a),
    .in_b  (in_b),
    .match (match)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_hit(input logic [1:0] p);
    return (m_seen >= 3) && (m2 == 2'b00) && (m1 == 2'b00) && (m0 == 2'b11) && (p == 2'b10);
  endfunction

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: match=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    m0 = 2'b00; m1 = 2'b00; m2 = 2'b00; m_seen = 0;
  endtask

  // one pair per cycle: drive after falling edge, check, then clock it in
  task automatic step(input logic [1:0] p, input string req);
    @(negedge clk);
    {in_a, in_b} = p;
    #1;
    check(match, model_hit(p), req);
    @(posedge clk);
    m2 = m1; m1 = m0; m0 = p;
    if (m_seen < 3) m_seen++;
  endtask

  task automatic do_reset(input logic [1:0] p_during);
    @(negedge clk);
    {in_a, in_b} = p_during;
    rst_n = 1'b0;
    #1;
    check(match, 1'b0, "R1 flag low in reset");
    repeat (2) @(posedge clk);
    #1;
    check(match, 1'b0, "R1 flag low across reset edges");
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic t_reset_state();
    do_reset(2'b10);
    step(2'b10, "R1 no match right after reset");
    step(2'b11, "R3 idle ignores 11");
    step(2'b10, "R3 idle ignores 10");
  endtask

  task automatic t_basic();
    step(2'b00, "R3 first zero");
    step(2'b00, "R4 second zero");
    step(2'b11, "R5 eleven arms");
    step(2'b10, "R2 basic match");
    step(2'b10, "R6 repeat 10 no match");
  endtask

  task automatic t_long_zero_run();
    for (int n = 3; n <= 9; n += 3) begin
      for (int i = 0; i < n; i++) step(2'b00, "R5 zero run");
      step(2'b11, "R5 arm after run");
      step(2'b10, "R5 match after long zero run");
    end
  endtask

  task automatic t_fallbacks();
    // one-zero broken by 01, by 11
    step(2'b00, "R4 setup");
    step(2'b01, "R4 break with 01");
    step(2'b11, "R4 after break");
    step(2'b10, "R4 no match after break");
    step(2'b00, "R4 setup");
    step(2'b11, "R4 break with 11");
    step(2'b10, "R4 no match");
    // two-zeros broken by 01 and 10
    step(2'b00, "R5 setup"); step(2'b00, "R5 setup");
    step(2'b01, "R5 break with 01");
    step(2'b11, "R5 after break"); step(2'b10, "R5 no match");
    step(2'b00, "R5 setup"); step(2'b00, "R5 setup");
    step(2'b10, "R5 break with 10");
    step(2'b11, "R5 after break"); step(2'b10, "R5 no match");
    // armed broken by 11, 01
    step(2'b00, "R6 setup"); step(2'b00, "R6 setup"); step(2'b11, "R6 setup");
    step(2'b11, "R6 armed sees 11");
    step(2'b10, "R6 no match after 11");
    step(2'b00, "R6 setup"); step(2'b00, "R6 setup"); step(2'b11, "R6 setup");
    step(2'b01, "R6 armed sees 01");
    step(2'b10, "R6 no match after 01");
  endtask

  task automatic t_armed_reentry();
    step(2'b00, "R6 setup"); step(2'b00, "R6 setup"); step(2'b11, "R6 setup");
    step(2'b00, "R6 armed sees 00");
    step(2'b00, "R6 second zero after reentry");
    step(2'b11, "R6 arm again");
    step(2'b10, "R6 match after reentry");
    // back-to-back matches with minimum spacing
    step(2'b00, "R6 b2b"); step(2'b00, "R6 b2b"); step(2'b11, "R6 b2b");
    step(2'b10, "R6 back-to-back match");
  endtask

  task automatic t_comb_output();
    step(2'b00, "R7 setup"); step(2'b00, "R7 setup"); step(2'b11, "R7 setup");
    @(negedge clk);
    {in_a, in_b} = 2'b10; #1; check(match, 1'b1, "R7 rises with 10");
    {in_a, in_b} = 2'b01; #1; check(match, 1'b0, "R7 falls with 01");
    {in_a, in_b} = 2'b10; #1; check(match, 1'b1, "R7 rises again");
    {in_a, in_b} = 2'b00; #1; check(match, 1'b0, "R7 falls with 00");
    @(posedge clk);
    m2 = m1; m1 = m0; m0 = 2'b00;
    step(2'b00, "R7 after toggle");
    step(2'b11, "R7 after toggle");
    step(2'b10, "R7 match after in-cycle toggle");
  endtask

  task automatic t_reset_midstream();
    step(2'b00, "R1 setup"); step(2'b00, "R1 setup"); step(2'b11, "R1 setup");
    do_reset(2'b10);
    step(2'b10, "R1 prefix forgotten");
    step(2'b00, "R1 fresh"); step(2'b00, "R1 fresh"); step(2'b11, "R1 fresh");
    step(2'b10, "R1 match after release");
  endtask

  task automatic t_random();
    logic [1:0] p;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 5)       p = 2'b00;
      else if (r < 7)  p = 2'b11;
      else if (r < 9)  p = 2'b10;
      else             p = 2'b01;
      step(p, "R2 random stream");
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    model_clear();
    in_a = 1'b0;
    in_b = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    t_reset_state();
    t_basic();
    t_long_zero_run();
    t_fallbacks();
    t_armed_reentry();
    t_comb_output();
    t_reset_midstream();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected end within %0d cycles", WATCHDOG_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule